// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from two groups of sources into sticky status bits and raises one interrupt line per group while any unmasked status bit is set. The first group (general sources) has a status register and a separate mask register. The second group (DMA channel completions) packs its status bits and its mask bits into one 32-bit word. Status bits sit in the low half of that word and mask bits sit in the high half.

Software reads the registers over a simple register bus. Read data is combinational from the address. Software clears status bits by writing ones to them. A write of an all-zero word to the general status register clears every bit in it. A status write to the DMA word never changes its mask half. The DMA mask is loaded through a second address, and that write leaves the status bits alone. If a source pulse and a software clear hit the same bit in the same cycle, the pulse wins, so no event is lost.

Top module: `isr_unit`

## Requirements
- R1: After a synchronous active-low reset, every status and mask bit is 0, both interrupt outputs are low, and reads of 0xF000, 0xF010 and 0xE010 return 0.
- R2: A 1 on bit i of `main_src_i` at a clock edge sets general status bit i. The bit stays set until software clears it, and it reads back at bit i of address 0xF000 after that edge.
- R3: A write to 0xF000 with a nonzero 32-bit data word clears exactly those general status bits whose data bit is 1. All other bits are unchanged.
- R4: A write to 0xF000 with a data word of all zeros clears every general status bit.
- R5: A write to 0xF010 replaces the whole general mask with the low data bits. The mask reads back at 0xF010.
- R6: `irq_main_o` is high exactly while the bitwise AND of general status and general mask is nonzero.
- R7: A 1 on bit i of `dma_src_i` sets DMA status bit i. That bit reads back at bit i of the word at 0xE010, whose bits [31:16] hold the DMA mask.
- R8: A write to 0xE010 clears each DMA status bit whose data bit in [15:0] is 1. The mask half is kept, and an all-zero write clears nothing.
- R9: A write to 0xE020 loads the DMA mask from data bits [31:16] and leaves the DMA status unchanged. A read of 0xE020 returns the same packed word as 0xE010.
- R10: `irq_dma_o` is high exactly while the DMA status half AND the DMA mask half is nonzero.
- R11: A source pulse and a software clear of the same bit in the same cycle leave the bit set. This holds in both groups.
- R12: Reads of any other address return 0, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | 16 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| main_src_i | input | MAIN_W (16) | General source event pulses |
| dma_src_i | input | DMA_CH (16) | DMA channel completion pulses |
| irq_main_o | output | 1 | General interrupt request |
| irq_dma_o | output | 1 | DMA interrupt request |

## Verification
A status bit that is wrongly set, lost or not cleared shows up at the ports after one clock edge. It appears in the read word of its register, and it shows on the interrupt line when the mask bit is set. A corrupted mask half in the DMA word is visible in the next read of 0xE010, and it also shows on `irq_dma_o` while any status bit is pending. The bench runs a behavioural model alongside the design and compares both interrupt lines every cycle. It also compares a register read after every cycle, so any divergence is caught within one clock of the edge that caused it.

// File: rtl/isr_pkg.sv
// Shared definitions for the interrupt status and mask unit.
// Holds the register offsets and the read-select encoding.
package isr_pkg;

    localparam int unsigned ISR_AW   = 16;
    localparam int unsigned ISR_DW   = 32;
    localparam int unsigned ISR_HALF = 16;

    localparam logic [ISR_AW-1:0] OFS_MAIN_STAT = 16'hF000;
    localparam logic [ISR_AW-1:0] OFS_MAIN_MASK = 16'hF010;
    localparam logic [ISR_AW-1:0] OFS_DMA_STAT  = 16'hE010;
    localparam logic [ISR_AW-1:0] OFS_DMA_MASK  = 16'hE020;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MAIN_STAT,
        SEL_MAIN_MASK,
        SEL_DMA_WORD
    } isr_sel_e;

endpackage

// File: rtl/isr_decode.sv
// Address decoder for the register bus.
// Turns the address and write strobe into one write strobe per register
// and a read select. It also flags an all-zero write word.
// Assumes at most one access per cycle and a full-word data bus.
module isr_decode
    import isr_pkg::*;
(
    input  logic              wr_i,
    input  logic [ISR_AW-1:0] addr_i,
    input  logic [ISR_DW-1:0] wdata_i,
    output isr_sel_e          rd_sel_o,
    output logic              wr_main_stat_o,
    output logic              wr_main_mask_o,
    output logic              wr_dma_stat_o,
    output logic              wr_dma_mask_o,
    output logic              wdata_zero_o
);

    // Map the address onto a read select.
    always_comb begin
        unique case (addr_i)
            OFS_MAIN_STAT: rd_sel_o = SEL_MAIN_STAT;
            OFS_MAIN_MASK: rd_sel_o = SEL_MAIN_MASK;
            OFS_DMA_STAT,
            OFS_DMA_MASK:  rd_sel_o = SEL_DMA_WORD;
            default:       rd_sel_o = SEL_NONE;
        endcase
    end

    // Qualify each register's write strobe by its address.
    always_comb begin
        wr_main_stat_o = wr_i && (addr_i == OFS_MAIN_STAT);
        wr_main_mask_o = wr_i && (addr_i == OFS_MAIN_MASK);
        wr_dma_stat_o  = wr_i && (addr_i == OFS_DMA_STAT);
        wr_dma_mask_o  = wr_i && (addr_i == OFS_DMA_MASK);
        wdata_zero_o   = (wdata_i == '0);
    end

endmodule

// File: rtl/isr_sticky_bank.sv
// Bank of sticky status bits with write-one-to-clear.
// A source pulse sets a bit. A clear removes the bits given in clr_data_i.
// When CLEAR_ALL_ON_ZERO is set, a clear whose write word was all zero
// removes every bit. A pulse takes priority over a clear in the same cycle.
module isr_sticky_bank #(
    parameter int unsigned W                 = 16,
    parameter bit          CLEAR_ALL_ON_ZERO = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_data_i,
    input  logic         clr_all_i,
    output logic [W-1:0] stat_o
);

    logic         take_all;
    logic [W-1:0] clr_vec;

    // Work out which bits this cycle's clear removes.
    always_comb begin
        take_all = clr_all_i && CLEAR_ALL_ON_ZERO;
        if (!clr_en_i)     clr_vec = '0;
        else if (take_all) clr_vec = '1;
        else               clr_vec = clr_data_i;
    end

    // Hold one sticky bit per source.
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni)        bit_q <= 1'b0;
            else if (src_i[b])  bit_q <= 1'b1;
            else if (clr_vec[b]) bit_q <= 1'b0;
        end
        assign stat_o[b] = bit_q;
    end

endmodule

// File: rtl/isr_mask_reg.sv
// Mask register that a bus write replaces as a whole.
// It resets to all zeros, which masks every source.
module isr_mask_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    // Load the full mask on a write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)   mask_o <= '0;
        else if (wr_i) mask_o <= wdata_i;
    end

endmodule

// File: rtl/isr_unit.sv
// Interrupt status and mask unit (top).
// Has two groups: general sources with separate status and mask registers,
// and DMA completions with status and mask packed into one word.
// Each group drives a level interrupt while any unmasked status bit is set.
// Assumes MAIN_W <= 32 and DMA_CH <= 16.
module isr_unit
    import isr_pkg::*;
#(
    parameter int unsigned MAIN_W = 16,
    parameter int unsigned DMA_CH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [15:0]       bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [MAIN_W-1:0] main_src_i,
    input  logic [DMA_CH-1:0] dma_src_i,
    output logic              irq_main_o,
    output logic              irq_dma_o
);

    localparam int unsigned MASK_LO = ISR_HALF;
    localparam int unsigned MASK_HI = ISR_HALF + DMA_CH - 1;

    isr_sel_e          rd_sel;
    logic              wr_main_stat, wr_main_mask, wr_dma_stat, wr_dma_mask;
    logic              wdata_zero;
    logic [MAIN_W-1:0] main_stat_q, main_mask_q;
    logic [DMA_CH-1:0] dma_stat_q, dma_mask_q;
    logic [31:0]       dma_word;

    isr_decode u_dec (
        .wr_i           (bus_wr_i),
        .addr_i         (bus_addr_i),
        .wdata_i        (bus_wdata_i),
        .rd_sel_o       (rd_sel),
        .wr_main_stat_o (wr_main_stat),
        .wr_main_mask_o (wr_main_mask),
        .wr_dma_stat_o  (wr_dma_stat),
        .wr_dma_mask_o  (wr_dma_mask),
        .wdata_zero_o   (wdata_zero)
    );

    isr_sticky_bank #(.W(MAIN_W), .CLEAR_ALL_ON_ZERO(1'b1)) u_main_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (main_src_i),
        .clr_en_i   (wr_main_stat),
        .clr_data_i (bus_wdata_i[MAIN_W-1:0]),
        .clr_all_i  (wdata_zero),
        .stat_o     (main_stat_q)
    );

    isr_mask_reg #(.W(MAIN_W)) u_main_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_main_mask),
        .wdata_i (bus_wdata_i[MAIN_W-1:0]),
        .mask_o  (main_mask_q)
    );

    isr_sticky_bank #(.W(DMA_CH), .CLEAR_ALL_ON_ZERO(1'b0)) u_dma_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (dma_src_i),
        .clr_en_i   (wr_dma_stat),
        .clr_data_i (bus_wdata_i[DMA_CH-1:0]),
        .clr_all_i  (wdata_zero),
        .stat_o     (dma_stat_q)
    );

    isr_mask_reg #(.W(DMA_CH)) u_dma_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_dma_mask),
        .wdata_i (bus_wdata_i[MASK_HI:MASK_LO]),
        .mask_o  (dma_mask_q)
    );

    // Pack DMA status into the low half and the mask into the high half.
    always_comb begin
        dma_word                  = '0;
        dma_word[DMA_CH-1:0]      = dma_stat_q;
        dma_word[MASK_HI:MASK_LO] = dma_mask_q;
    end

    // Select the read data for the addressed register.
    always_comb begin
        bus_rdata_o = '0;
        unique case (rd_sel)
            SEL_MAIN_STAT: bus_rdata_o[MAIN_W-1:0] = main_stat_q;
            SEL_MAIN_MASK: bus_rdata_o[MAIN_W-1:0] = main_mask_q;
            SEL_DMA_WORD:  bus_rdata_o = dma_word;
            default:       bus_rdata_o = '0;
        endcase
    end

    // Raise each group's interrupt while any unmasked bit is pending.
    always_comb begin
        irq_main_o = |(main_stat_q & main_mask_q);
        irq_dma_o  = |(dma_stat_q & dma_mask_q);
    end

endmodule

// File: rtl/isr_unit_chk.sv
// Property checker for isr_unit. It is bound to every instance of the top.
// It observes the bus, the source inputs, the interrupt outputs and the
// four state registers.
module isr_unit_chk #(
    parameter int unsigned MAIN_W = 16,
    parameter int unsigned DMA_CH = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [15:0]       bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic [MAIN_W-1:0] main_src_i,
    input logic [DMA_CH-1:0] dma_src_i,
    input logic              irq_main_o,
    input logic              irq_dma_o,
    input logic [MAIN_W-1:0] main_stat_q,
    input logic [MAIN_W-1:0] main_mask_q,
    input logic [DMA_CH-1:0] dma_stat_q,
    input logic [DMA_CH-1:0] dma_mask_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (main_stat_q == '0 && main_mask_q == '0 &&
                     dma_stat_q == '0 && dma_mask_q == '0));

    // R2
    main_sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (main_src_i != '0) |=> ((main_stat_q & $past(main_src_i)) == $past(main_src_i)));

    // R11
    dma_pulse_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_src_i != '0) |=> ((dma_stat_q & $past(dma_src_i)) == $past(dma_src_i)));

    // R3
    main_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 16'hF000 && main_src_i == '0)
        |=> ((main_stat_q & $past(bus_wdata_i[MAIN_W-1:0])) == '0));

    // R4
    main_zero_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 16'hF000 && bus_wdata_i == '0 && main_src_i == '0)
        |=> (main_stat_q == '0));

    // R8
    dma_mask_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 16'hE010) |=> $stable(dma_mask_q));

    // R9
    dma_stat_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 16'hE020 && dma_src_i == '0) |=> $stable(dma_stat_q));

    // R6
    main_irq_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_main_o |-> (main_stat_q != '0 && main_mask_q != '0));

    // R10
    dma_irq_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_dma_o |-> (dma_stat_q != '0 && dma_mask_q != '0));

endmodule

bind isr_unit isr_unit_chk #(.MAIN_W(MAIN_W), .DMA_CH(DMA_CH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .main_src_i  (main_src_i),
    .dma_src_i   (dma_src_i),
    .irq_main_o  (irq_main_o),
    .irq_dma_o   (irq_dma_o),
    .main_stat_q (main_stat_q),
    .main_mask_q (main_mask_q),
    .dma_stat_q  (dma_stat_q),
    .dma_mask_q  (dma_mask_q)
);

// File: tb/tb_isr_unit.sv
// Self-checking bench for isr_unit with a behavioural reference model.
module tb_isr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [15:0] msrc = 16'h0;
    logic [15:0] dsrc = 16'h0;
    logic        irq_m, irq_d;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    bit [15:0] m_ms = 0, m_mm = 0, m_ds = 0, m_dm = 0;

    always #5 clk = ~clk;

    isr_unit dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .main_src_i(msrc),
        .dma_src_i(dsrc), .irq_main_o(irq_m), .irq_dma_o(irq_d)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] model_rd(input bit [15:0] a);
        case (a)
            16'hF000: return {16'h0, m_ms};
            16'hF010: return {16'h0, m_mm};
            16'hE010, 16'hE020: return {m_dm, m_ds};
            default: return 32'h0;
        endcase
    endfunction

    // One clock with the given stimulus; the model advances and the irqs are compared.
    task automatic cyc(input bit w, input bit [15:0] a, input bit [31:0] d,
                       input bit [15:0] ms, input bit [15:0] ds);
        bit [15:0] clr;
        bit [15:0] n_ms, n_mm, n_ds, n_dm;
        wr = w; addr = a; wdata = d; msrc = ms; dsrc = ds;
        clr  = (w && a == 16'hF000) ? ((d == 0) ? 16'hFFFF : d[15:0]) : 16'h0;
        n_ms = (m_ms & ~clr) | ms;
        n_mm = (w && a == 16'hF010) ? d[15:0] : m_mm;
        clr  = (w && a == 16'hE010) ? d[15:0] : 16'h0;
        n_ds = (m_ds & ~clr) | ds;
        n_dm = (w && a == 16'hE020) ? d[31:16] : m_dm;
        @(posedge clk); #1;
        m_ms = n_ms; m_mm = n_mm; m_ds = n_ds; m_dm = n_dm;
        wr = 0; msrc = 0; dsrc = 0;
        chk(irq_m == ((m_ms & m_mm) != 0), "R6 irq_main", {31'h0, irq_m}, {31'h0, (m_ms & m_mm) != 0});
        chk(irq_d == ((m_ds & m_dm) != 0), "R10 irq_dma", {31'h0, irq_d}, {31'h0, (m_ds & m_dm) != 0});
    endtask

    task automatic rd(input bit [15:0] a, input string tag);
        addr = a; #1;
        chk(rdata == model_rd(a), tag, rdata, model_rd(a));
    endtask

    task automatic rd_exp(input bit [15:0] a, input bit [31:0] e, input string tag);
        addr = a; #1;
        chk(rdata == e, tag, rdata, e);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd_exp(16'hF000, 0, "R1 main status");
        rd_exp(16'hF010, 0, "R1 main mask");
        rd_exp(16'hE010, 0, "R1 dma word");
        chk(irq_m == 0 && irq_d == 0, "R1 irqs", {30'h0, irq_m, irq_d}, 0);

        // R2 sticky set, masked so no irq
        cyc(0, 0, 0, 16'h0005, 0);
        cyc(0, 0, 0, 0, 0);
        rd_exp(16'hF000, 32'h5, "R2 sticky status");
        // R5 mask write, R6 irq rises
        cyc(1, 16'hF010, 32'h0000_0004, 0, 0);
        rd_exp(16'hF010, 32'h4, "R5 mask readback");
        chk(irq_m == 1, "R6 irq on", {31'h0, irq_m}, 1);
        // R3 selective clear
        cyc(1, 16'hF000, 32'h0000_0004, 0, 0);
        rd_exp(16'hF000, 32'h1, "R3 selective clear");
        chk(irq_m == 0, "R6 irq off", {31'h0, irq_m}, 0);
        // R4 zero word clears all
        cyc(0, 0, 0, 16'h00F0, 0);
        cyc(1, 16'hF000, 32'h0, 0, 0);
        rd_exp(16'hF000, 32'h0, "R4 zero clears all");
        // R11 pulse beats clear (main)
        cyc(1, 16'hF000, 32'h0000_0008, 16'h0008, 0);
        rd_exp(16'hF000, 32'h8, "R11 main pulse wins");

        // R7 dma set
        cyc(0, 0, 0, 0, 16'h0003);
        rd_exp(16'hE010, 32'h0000_0003, "R7 dma status");
        // R9 mask load, status untouched despite low bits set
        cyc(1, 16'hE020, 32'h0002_FFFF, 0, 0);
        rd_exp(16'hE010, 32'h0002_0003, "R9 dma mask load");
        rd_exp(16'hE020, 32'h0002_0003, "R9 alias read");
        chk(irq_d == 1, "R10 irq on", {31'h0, irq_d}, 1);
        // R8 clear keeps mask
        cyc(1, 16'hE010, 32'hFFFF_0002, 0, 0);
        rd_exp(16'hE010, 32'h0002_0001, "R8 dma clear keeps mask");
        chk(irq_d == 0, "R10 irq off", {31'h0, irq_d}, 0);
        cyc(1, 16'hE010, 32'h0, 0, 0);
        rd_exp(16'hE010, 32'h0002_0001, "R8 zero write clears nothing");
        // R11 pulse beats clear (dma)
        cyc(1, 16'hE010, 32'h0000_0002, 0, 16'h0002);
        rd_exp(16'hE010, 32'h0002_0003, "R11 dma pulse wins");
        // R12 unmapped
        cyc(1, 16'h1234, 32'hFFFF_FFFF, 0, 0);
        cyc(1, 16'hF004, 32'h0, 0, 0);
        rd_exp(16'h1234, 32'h0, "R12 unmapped read");
        rd_exp(16'hF000, 32'h8, "R12 main untouched");
        rd_exp(16'hF010, 32'h4, "R12 mask untouched");
        rd_exp(16'hE010, 32'h0002_0003, "R12 dma untouched");

        // Mixed stimulus against the model
        for (int i = 0; i < 400; i++) begin
            bit [15:0] a;
            bit [31:0] d;
            int sel = $urandom_range(0, 5);
            case (sel)
                0: a = 16'hF000;
                1: a = 16'hF010;
                2: a = 16'hE010;
                3: a = 16'hE020;
                4: a = 16'h0100;
                default: a = 16'hF020;
            endcase
            d = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
            cyc($urandom_range(0, 1) == 1, a, d,
                16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom));
            rd(a, "R2/R3/R4/R5/R7/R8/R9/R12 model read");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule